// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block decides, cycle by cycle, what an in-order five-stage pipeline without forwarding may do. The stages are fetch, decode with register read, operand fetch, execute and write-back. Each stage takes one clock. The controller keeps a control-only shadow of the instructions in the four registered stages. For each instruction it holds the source registers, the destination, the write flag and the memory-operand flags. From that shadow it finds two kinds of conflict.

The first conflict is on the single-port unified memory. An instruction fetch cannot share a cycle with a data read or a data write. The second conflict is a read-after-write dependency on a register. When either occurs, the controller holds the younger stages, injects bubbles and tells the front end whether it may fetch.

The front end presents the next instruction's descriptor with `f_avail`. It holds that descriptor until `fetch_go` accepts it. The datapath uses `stage_en`, `bubble` and `mem_grant` to steer its own pipeline registers and the memory port. Two counters total the cycles lost to each kind of hazard.

Top module: `hz_stall_ctrl`

## Requirements
- R1: While `rst_n` is low and just after it is released, `stage_valid` is 0, both stall counters read 0, and with `f_avail` low `fetch_go` is 0 and `mem_grant` is 0 (idle).
- R2: With no hazard, one instruction is accepted per cycle, and `mem_grant` reads 1 (fetch) in each accepting cycle.
- R3: A valid instruction in decode that reads a register is held there while a valid instruction in operand fetch or execute will write that register. A writer in write-back does not conflict, because the register file writes in the first half of the cycle and reads in the second half. So a dependent instruction that directly follows its producer loses exactly 2 cycles, one two places behind loses 1, and one three places behind loses none.
- R4: Register 0, and destinations whose write flag is clear, never cause a dependency stall.
- R5: In a dependency stall (with no data-data conflict), fetch and decode hold, and a bubble enters operand fetch. Execute and write-back still advance. That is, `stage_en` = 4'b1100 and `bubble` = 3'b010. Bit order for `stage_en` is [0] decode, [1] operand fetch, [2] execute, [3] write-back. Bit order for `bubble` is [0] decode, [1] operand fetch, [2] execute.
- R6: A valid operand-fetch instruction with a memory read, or a valid write-back instruction with a memory write, takes the memory port in that cycle. Fetch then idles and a bubble enters decode (`bubble` = 3'b001). `mem_grant` reads 2 for the operand-fetch read and 3 for the write-back write.
- R7: When both data accesses fall in one cycle, the older write-back write wins (`mem_grant` = 3). Operand fetch, decode and fetch hold, and a bubble enters execute (`stage_en` = 4'b1000, `bubble` = 3'b100). The held read takes the port in the next cycle (`mem_grant` = 2).
- R8: `raw_stalls` rises by one for every cycle in which decode is held by a register dependency, and saturates at all ones.
- R9: `port_stalls` rises by one for every cycle in which a data access holds the port while `f_avail` is high and no dependency stall is active, and saturates at all ones.
- R10: `fetch_go` is never high while `f_avail` is low, so no instruction enters the pipeline without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_avail | input | 1 | A descriptor is waiting to be fetched |
| f_src | input | NSRC*REG_W (10) | Source registers; slot k sits at bits [k*REG_W +: REG_W] |
| f_rd | input | REG_W (5) | Destination register |
| f_rd_we | input | 1 | Instruction writes `f_rd` |
| f_mem_rd | input | 1 | Instruction reads a memory operand in operand fetch |
| f_mem_wr | input | 1 | Instruction writes memory in write-back |
| fetch_go | output | 1 | Descriptor accepted and memory port used for fetch this cycle |
| stage_en | output | 4 | Load enables for decode, operand fetch, execute, write-back |
| bubble | output | 3 | Bubble inject into decode, operand fetch, execute |
| mem_grant | output | 2 | Port owner: 0 idle, 1 fetch, 2 operand read, 3 write-back write |
| stage_valid | output | 4 | Valid bits of decode, operand fetch, execute, write-back |
| raw_stalls | output | CNT_W (16) | Dependency stall cycle count |
| port_stalls | output | CNT_W (16) | Memory port stall cycle count |

## Verification
`fetch_go`, `mem_grant`, `stage_en` and `bubble` are combinational from the shadow state and the current request, so they are due in the same cycle as the stimulus. `stage_valid` and the counters change at the following rising edge. The bench drives each descriptor at a falling edge and samples the combinational outputs 1 ns later. It logs them per cycle, counted from the first presented instruction, and compares them with hand-derived cycle numbers for each scripted sequence. It reads the counters only after the pipeline has drained, as differences from the value before the sequence.

// File: rtl/hz_pkg.sv
package hz_pkg;
  parameter int unsigned REG_W = 5;
  parameter int unsigned NSRC  = 2;
  localparam int unsigned SRC_W = REG_W * NSRC;

  typedef enum logic [1:0] {
    GNT_IDLE    = 2'd0,
    GNT_FETCH   = 2'd1,
    GNT_DATA_FO = 2'd2,
    GNT_DATA_WO = 2'd3
  } grant_e;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [REG_W-1:0] rd;
    logic             rd_we;
    logic             mem_rd;
    logic             mem_wr;
  } instr_t;

  localparam instr_t INSTR_NOP = '0;

  // a producer only counts when it is live, writes, and targets a real register
  function automatic logic writes_reg(instr_t i, logic v);
    return v && i.rd_we && (i.rd != '0);
  endfunction

  function automatic logic reads_reg(instr_t i, logic [REG_W-1:0] r);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (r != '0 && i.src[k*REG_W +: REG_W] == r) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic logic depends_on(instr_t c, instr_t p, logic pv);
    return writes_reg(p, pv) && reads_reg(c, p.rd);
  endfunction
endpackage

// File: rtl/hz_raw_detect.sv
module hz_raw_detect
  import hz_pkg::*;
#(
  parameter int unsigned NPROD = 2
) (
  input  instr_t             cons,
  input  logic               cons_v,
  input  instr_t             prod [NPROD],
  input  logic [NPROD-1:0]   prod_v,
  output logic [NPROD-1:0]   hit,
  output logic               raw
);
  // one comparator bank per producing stage
  for (genvar p = 0; p < NPROD; p++) begin : g_prod
    assign hit[p] = cons_v && depends_on(cons, prod[p], prod_v[p]);
  end
  assign raw = |hit;
endmodule

// File: rtl/hz_port_arb.sv
module hz_port_arb
  import hz_pkg::*;
(
  input  logic   f_avail,
  input  logic   fo_v,
  input  logic   fo_mem_rd,
  input  logic   wo_v,
  input  logic   wo_mem_wr,
  input  logic   raw,
  output grant_e grant,
  output logic   fo_hold,
  output logic   data_busy,
  output logic   fetch_go
);
  logic fo_req, wo_req;

  always_comb begin
    fo_req    = fo_v && fo_mem_rd;
    wo_req    = wo_v && wo_mem_wr;
    data_busy = fo_req || wo_req;
    // older write-back access wins; the operand read waits one cycle
    fo_hold   = fo_req && wo_req;
    fetch_go  = f_avail && !raw && !data_busy;
    if (wo_req)        grant = GNT_DATA_WO;
    else if (fo_req)   grant = GNT_DATA_FO;
    else if (fetch_go) grant = GNT_FETCH;
    else               grant = GNT_IDLE;
  end
endmodule

// File: rtl/hz_stage_ctrl.sv
module hz_stage_ctrl
  import hz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_go,
  input  instr_t     f_instr,
  input  logic       raw,
  input  logic       fo_hold,
  output instr_t     di_q,
  output instr_t     fo_q,
  output instr_t     ei_q,
  output instr_t     wo_q,
  output logic [3:0] v_q,
  output logic [3:0] en,
  output logic [2:0] bub
);
  logic di_hold;

  always_comb begin
    di_hold = raw || fo_hold;
    en[0]   = fetch_go;
    en[1]   = !fo_hold && !raw;
    en[2]   = !fo_hold;
    en[3]   = 1'b1;
    bub[0]  = !di_hold && !fetch_go;
    bub[1]  = raw && !fo_hold;
    bub[2]  = fo_hold;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= '0;
      di_q <= INSTR_NOP;
      fo_q <= INSTR_NOP;
      ei_q <= INSTR_NOP;
      wo_q <= INSTR_NOP;
    end else begin
      wo_q   <= ei_q;
      v_q[3] <= v_q[2];
      if (en[2]) begin
        ei_q   <= fo_q;
        v_q[2] <= v_q[1];
      end else begin
        v_q[2] <= 1'b0;
      end
      if (en[1]) begin
        fo_q   <= di_q;
        v_q[1] <= v_q[0];
      end else if (bub[1]) begin
        v_q[1] <= 1'b0;
      end
      if (en[0]) begin
        di_q   <= f_instr;
        v_q[0] <= 1'b1;
      end else if (bub[0]) begin
        v_q[0] <= 1'b0;
      end
    end
  end

  a_r5_raw_bubble_fo: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !fo_hold) |=> !v_q[1]);
  a_r5_raw_holds_di: assert property (@(posedge clk) disable iff (!rst_n)
    raw |=> (v_q[0] && $stable(di_q)));
  a_r7_fo_held: assert property (@(posedge clk) disable iff (!rst_n)
    fo_hold |=> (v_q[1] && $stable(fo_q) && !v_q[2]));
endmodule

// File: rtl/hz_sat_counter.sv
module hz_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt));
  a_r9_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    f_avail,
  input  logic [hz_pkg::SRC_W-1:0] f_src,
  input  logic [hz_pkg::REG_W-1:0] f_rd,
  input  logic                    f_rd_we,
  input  logic                    f_mem_rd,
  input  logic                    f_mem_wr,
  output logic                    fetch_go,
  output logic [3:0]              stage_en,
  output logic [2:0]              bubble,
  output logic [1:0]              mem_grant,
  output logic [3:0]              stage_valid,
  output logic [CNT_W-1:0]        raw_stalls,
  output logic [CNT_W-1:0]        port_stalls
);
  localparam int unsigned NPROD = 2;

  instr_t           f_instr, di_q, fo_q, ei_q, wo_q;
  instr_t           prod [NPROD];
  logic [NPROD-1:0] prod_v, raw_hit;
  logic [3:0]       v_q;
  logic             raw, fo_hold, data_busy, go;
  grant_e           grant;
  logic             raw_inc, port_inc;

  assign f_instr = '{src: f_src, rd: f_rd, rd_we: f_rd_we,
                     mem_rd: f_mem_rd, mem_wr: f_mem_wr};
  assign prod[0] = fo_q;
  assign prod[1] = ei_q;
  assign prod_v  = {v_q[2], v_q[1]};

  hz_raw_detect #(.NPROD(NPROD)) u_raw (
    .cons(di_q), .cons_v(v_q[0]), .prod(prod), .prod_v(prod_v),
    .hit(raw_hit), .raw(raw));

  hz_port_arb u_arb (
    .f_avail(f_avail), .fo_v(v_q[1]), .fo_mem_rd(fo_q.mem_rd),
    .wo_v(v_q[3]), .wo_mem_wr(wo_q.mem_wr), .raw(raw),
    .grant(grant), .fo_hold(fo_hold), .data_busy(data_busy), .fetch_go(go));

  hz_stage_ctrl u_stages (
    .clk(clk), .rst_n(rst_n), .fetch_go(go), .f_instr(f_instr),
    .raw(raw), .fo_hold(fo_hold), .di_q(di_q), .fo_q(fo_q), .ei_q(ei_q),
    .wo_q(wo_q), .v_q(v_q), .en(stage_en), .bub(bubble));

  assign raw_inc  = raw;
  assign port_inc = data_busy && f_avail && !raw;

  hz_sat_counter #(.W(CNT_W)) u_raw_cnt (
    .clk(clk), .rst_n(rst_n), .inc(raw_inc), .cnt(raw_stalls));
  hz_sat_counter #(.W(CNT_W)) u_port_cnt (
    .clk(clk), .rst_n(rst_n), .inc(port_inc), .cnt(port_stalls));

  assign fetch_go    = go;
  assign mem_grant   = grant;
  assign stage_valid = v_q;

  a_r10_fetch_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |-> f_avail);
  a_r6_data_owns_port: assert property (@(posedge clk) disable iff (!rst_n)
    ((v_q[1] && fo_q.mem_rd) || (v_q[3] && wo_q.mem_wr)) |-> (mem_grant != GNT_FETCH && !fetch_go));
  a_r3_no_early_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q[0] && (depends_on(di_q, fo_q, v_q[1]) || depends_on(di_q, ei_q, v_q[2]))) |-> !stage_en[1]);
  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q[1] && fo_q.mem_rd && v_q[3] && wo_q.mem_wr) |-> (mem_grant == GNT_DATA_WO && bubble[2]));
endmodule

// File: tb/hz_stall_ctrl_tb.sv
`timescale 1ns/1ps
module hz_stall_ctrl_tb;
  localparam int RW = hz_pkg::REG_W;
  localparam int SW = hz_pkg::SRC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic f_avail = 1'b0;
  logic [SW-1:0] f_src = '0;
  logic [RW-1:0] f_rd = '0;
  logic f_rd_we = 1'b0, f_mem_rd = 1'b0, f_mem_wr = 1'b0;
  logic fetch_go;
  logic [3:0] stage_en, stage_valid;
  logic [2:0] bubble;
  logic [1:0] mem_grant;
  logic [15:0] raw_stalls, port_stalls;

  int checks = 0;
  int errors = 0;

  logic [SW-1:0] p_src [8];
  logic [RW-1:0] p_rd [8];
  logic p_we [8], p_mr [8], p_mw [8];
  int   fetch_at [8];
  logic [1:0] g_log [32];
  logic [2:0] b_log [32];
  logic [3:0] e_log [32];
  int raw0, port0;

  always #2.5 clk = ~clk;

  hz_stall_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .f_avail(f_avail), .f_src(f_src), .f_rd(f_rd),
    .f_rd_we(f_rd_we), .f_mem_rd(f_mem_rd), .f_mem_wr(f_mem_wr),
    .fetch_go(fetch_go), .stage_en(stage_en), .bubble(bubble),
    .mem_grant(mem_grant), .stage_valid(stage_valid),
    .raw_stalls(raw_stalls), .port_stalls(port_stalls));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_i(input int k, input int rd, input bit we, input int s1,
                       input int s2, input bit mr, input bit mw);
    p_rd[k]  = RW'(rd);
    p_we[k]  = we;
    p_src[k] = {RW'(s2), RW'(s1)};
    p_mr[k]  = mr;
    p_mw[k]  = mw;
  endtask

  task automatic run_prog(input int n);
    int cyc = 0;
    int k = 0;
    raw0 = raw_stalls;
    port0 = port_stalls;
    for (int i = 0; i < 32; i++) begin
      g_log[i] = '0; b_log[i] = '0; e_log[i] = '0;
    end
    while (k < n && cyc < 30) begin
      @(negedge clk);
      f_avail = 1'b1; f_src = p_src[k]; f_rd = p_rd[k]; f_rd_we = p_we[k];
      f_mem_rd = p_mr[k]; f_mem_wr = p_mw[k];
      #1;
      g_log[cyc] = mem_grant; b_log[cyc] = bubble; e_log[cyc] = stage_en;
      if (fetch_go) begin fetch_at[k] = cyc; k++; end
      cyc++;
    end
    for (int d = 0; d < 8; d++) begin
      @(negedge clk);
      f_avail = 1'b0; f_mem_rd = 1'b0; f_mem_wr = 1'b0;
      #1;
      if (cyc < 32) begin
        g_log[cyc] = mem_grant; b_log[cyc] = bubble; e_log[cyc] = stage_en;
      end
      chk("R10 fetch without request", int'(fetch_go), 0);
      cyc++;
    end
    chk("R10 pipeline drained", int'(stage_valid), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid in reset", int'(stage_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 valid after reset", int'(stage_valid), 0);
    chk("R1 raw count", int'(raw_stalls), 0);
    chk("R1 port count", int'(port_stalls), 0);
    chk("R1 fetch_go idle", int'(fetch_go), 0);
    chk("R1 grant idle", int'(mem_grant), 0);
  endtask

  task automatic t_no_hazard;
    for (int k = 0; k < 4; k++) set_i(k, k + 1, 1, 10, 11, 0, 0);
    run_prog(4);
    for (int k = 0; k < 4; k++) chk("R2 fetch cycle", fetch_at[k], k);
    chk("R2 grant fetch", int'(g_log[0]), 1);
    chk("R2 grant fetch", int'(g_log[3]), 1);
    chk("R8 no raw stalls", raw_stalls - raw0, 0);
  endtask

  task automatic t_raw_adjacent;
    set_i(0, 1, 1, 10, 11, 0, 0);
    set_i(1, 6, 1, 1, 12, 0, 0);
    set_i(2, 7, 1, 13, 14, 0, 0);
    run_prog(3);
    chk("R3 adjacent fetch I1", fetch_at[1], 1);
    chk("R3 adjacent fetch I2", fetch_at[2], 4);
    chk("R8 adjacent raw count", raw_stalls - raw0, 2);
    chk("R9 no port count in raw", port_stalls - port0, 0);
    chk("R5 bubble into FO", int'(b_log[2]), 3'b010);
    chk("R5 stage enables", int'(e_log[2]), 4'b1100);
  endtask

  task automatic t_raw_distance;
    set_i(0, 2, 1, 10, 11, 0, 0);
    set_i(1, 8, 1, 12, 13, 0, 0);
    set_i(2, 9, 1, 14, 2, 0, 0);
    set_i(3, 4, 1, 15, 16, 0, 0);
    run_prog(4);
    chk("R3 distance two I3", fetch_at[3], 4);
    chk("R8 distance two count", raw_stalls - raw0, 1);
    set_i(0, 3, 1, 10, 11, 0, 0);
    set_i(1, 8, 1, 12, 13, 0, 0);
    set_i(2, 9, 1, 14, 15, 0, 0);
    set_i(3, 4, 1, 3, 16, 0, 0);
    run_prog(4);
    chk("R3 distance three I3", fetch_at[3], 3);
    chk("R3 writer in WO no stall", raw_stalls - raw0, 0);
  endtask

  task automatic t_reg_zero;
    set_i(0, 0, 1, 10, 11, 0, 0);
    set_i(1, 5, 0, 0, 0, 0, 0);
    set_i(2, 7, 1, 5, 0, 0, 0);
    run_prog(3);
    chk("R4 r0 ignored", fetch_at[1], 1);
    chk("R4 no-write ignored", fetch_at[2], 2);
    chk("R4 raw count", raw_stalls - raw0, 0);
  endtask

  task automatic t_mem_read;
    set_i(0, 0, 0, 10, 0, 1, 0);
    for (int k = 1; k < 4; k++) set_i(k, k + 1, 1, 12, 13, 0, 0);
    run_prog(4);
    chk("R6 read grant", int'(g_log[2]), 2);
    chk("R6 fetch idles", fetch_at[2], 3);
    chk("R6 bubble into DI", int'(b_log[2]), 3'b001);
    chk("R6 enables", int'(e_log[2]), 4'b1110);
    chk("R9 read port count", port_stalls - port0, 1);
  endtask

  task automatic t_mem_write;
    set_i(0, 0, 0, 10, 11, 0, 1);
    for (int k = 1; k < 5; k++) set_i(k, k + 1, 1, 12, 13, 0, 0);
    run_prog(5);
    chk("R6 write grant", int'(g_log[4]), 3);
    chk("R6 fetch after write", fetch_at[4], 5);
    chk("R9 write port count", port_stalls - port0, 1);
  endtask

  task automatic t_data_clash;
    set_i(0, 0, 0, 10, 11, 0, 1);
    set_i(1, 2, 1, 12, 13, 0, 0);
    set_i(2, 0, 0, 14, 0, 1, 0);
    set_i(3, 3, 1, 15, 16, 0, 0);
    set_i(4, 4, 1, 17, 18, 0, 0);
    run_prog(5);
    chk("R7 write wins", int'(g_log[4]), 3);
    chk("R7 bubble into EI", int'(b_log[4]), 3'b100);
    chk("R7 enables", int'(e_log[4]), 4'b1000);
    chk("R7 held read next", int'(g_log[5]), 2);
    chk("R7 fetch resumes", fetch_at[4], 6);
    chk("R7 fetch grant", int'(g_log[6]), 1);
    chk("R9 clash port count", port_stalls - port0, 2);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_no_hazard();
    t_raw_adjacent();
    t_raw_distance();
    t_reg_zero();
    t_mem_read();
    t_mem_write();
    t_data_clash();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule